// File: doc/BRIEF.md
# SCL Two-Stage Clock Divider

This block derives a serial-bus clock from the fast module input clock. A prescaler divides the input by a programmable amount plus one, producing a one-cycle enable pulse (the module tick). Two phase counters, clocked by that tick, set how long the serial clock stays low and then high. Each phase lasts its programmed count plus a fixed offset. The offset depends on the prescaler setting, so the period in input cycles is (prescale+1) × ((lowCount + offset) + (highCount + offset)).

Software writes the three divider values while the block is held idle, with `enable` low. It then raises `enable`, and the values are captured at that moment. While idle the serial clock rests high and every counter is cleared. A run always opens with a complete low phase. The prescaler should be chosen so that the module tick rate falls between 7 and 12 MHz. The block does not enforce this range.

Top module: `scl_div_gen`

## Requirements
- R1: While `enable` is low, starting one cycle after it is sampled low, `scl` is 1, `sclPhase` is 0 and `tick` is 0.
- R2: `scl` falls in the cycle after `enable` is first sampled high. It then stays low for exactly (pscIn+1) × (lowIn + offset) cycles.
- R3: Each high phase lasts exactly (pscIn+1) × (highIn + offset) cycles. It is followed by a further low phase of the length in R2, repeating while `enable` stays high.
- R4: The offset is 7 when pscIn is 0.
- R5: The offset is 6 when pscIn is 1.
- R6: The offset is 5 when pscIn is 2 or more.
- R7: While running, `tick` is a one-cycle pulse repeating every pscIn+1 cycles. When pscIn is 0 it is high in every cycle.
- R8: The divider inputs are captured on the clock edge that first samples `enable` high. Changes to them during a run have no effect until `enable` has been low and is raised again.
- R9: When `enable` drops in the middle of a phase, `scl` returns high one cycle later. The next run starts with a full low phase.
- R10: `sclPhase` is 1 during high phases and 0 during low phases and while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module input clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Low holds the divider idle and loads settings; high runs it |
| pscIn | input | 16 | Prescaler setting; module tick every pscIn+1 cycles |
| lowIn | input | 16 | Low-phase count, before the offset is added |
| highIn | input | 16 | High-phase count, before the offset is added |
| scl | output | 1 | Generated serial clock |
| sclPhase | output | 1 | 1 during the high phase of a run |
| tick | output | 1 | Module-clock enable pulse |

## Verification
The assertions assume that at least one clock edge occurs while reset is applied. They also assume that the divider inputs hold steady across the edge where `enable` is first sampled high, since any value present on that edge is captured. The stimulus changes the divider inputs only while `enable` is low, with the single exception of the deliberate mid-run change that tests R8. Every `enable` change is driven one nanosecond after a rising edge. The chosen settings keep each phase short enough that whole periods fit within a few hundred cycles.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

  // Phase offsets added to each programmed count, selected by prescaler value
  localparam int unsigned OFS_PSC_ZERO = 7;
  localparam int unsigned OFS_PSC_ONE  = 6;
  localparam int unsigned OFS_PSC_MORE = 5;

  // Strobes from control to datapath
  typedef struct packed {
    logic hold;      // divider idle: load settings, clear counters
    logic tick;      // module-clock enable this cycle
    logic phaseHigh; // current phase is the high phase
  } sclStrobe_t;

endpackage

// File: rtl/scl_div_dpath.sv
module scl_div_dpath
  import scl_div_pkg::*;
#(
  parameter int unsigned REG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  sclStrobe_t       strb,
  input  logic [REG_W-1:0] pscIn,
  input  logic [REG_W-1:0] lowIn,
  input  logic [REG_W-1:0] highIn,
  output logic [REG_W-1:0] pscHeld,
  output logic             phaseDone
);

  localparam int unsigned LEN_W = REG_W + 1;
  localparam int unsigned NUM_PHASES = 2;

  logic [LEN_W-1:0] offset;
  logic [NUM_PHASES-1:0][REG_W-1:0] countIn;
  logic [NUM_PHASES-1:0][LEN_W-1:0] lenHeld;
  logic [LEN_W-1:0] curLen;
  logic [LEN_W-1:0] phaseCnt;

  // Offset chosen from the prescaler value being loaded
  always_comb begin
    if (pscIn == '0)
      offset = LEN_W'(OFS_PSC_ZERO);
    else if (pscIn == REG_W'(1))
      offset = LEN_W'(OFS_PSC_ONE);
    else
      offset = LEN_W'(OFS_PSC_MORE);
  end

  assign countIn[0] = lowIn;
  assign countIn[1] = highIn;

  // One length register per phase, loaded while idle
  for (genvar g = 0; g < NUM_PHASES; g++) begin : g_phaseLen
    logic [LEN_W-1:0] lenQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        lenQ <= '0;
      else if (strb.hold)
        lenQ <= LEN_W'(countIn[g]) + offset;
    end
    assign lenHeld[g] = lenQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      pscHeld <= '0;
    else if (strb.hold)
      pscHeld <= pscIn;
  end

  assign curLen    = strb.phaseHigh ? lenHeld[1] : lenHeld[0];
  assign phaseDone = strb.tick && (phaseCnt == curLen - LEN_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      phaseCnt <= '0;
    else if (strb.hold)
      phaseCnt <= '0;
    else if (strb.tick)
      phaseCnt <= phaseDone ? '0 : phaseCnt + LEN_W'(1);
  end

  // Loaded lengths always include at least the smallest offset
  assert_len_floor_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.hold |-> (lenHeld[0] >= LEN_W'(OFS_PSC_MORE)) && (lenHeld[1] >= LEN_W'(OFS_PSC_MORE)));

  // Phase counter never reaches the active phase length
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.hold |-> phaseCnt < curLen);

  // Settings frozen during a run
  assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.hold && !$past(strb.hold)) |-> ($stable(pscHeld) && $stable(lenHeld)));

endmodule

// File: rtl/scl_div_ctrl.sv
module scl_div_ctrl
  import scl_div_pkg::*;
#(
  parameter int unsigned REG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [REG_W-1:0] pscHeld,
  input  logic             phaseDone,
  output sclStrobe_t       strb,
  output logic             scl,
  output logic             sclPhase,
  output logic             tick
);

  logic             running;
  logic [REG_W-1:0] preCnt;
  logic             phaseHigh;
  logic             preWrap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      running <= 1'b0;
    else
      running <= enable;
  end

  // Prescaler: wraps after pscHeld+1 cycles
  assign preWrap = running && (preCnt == pscHeld);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      preCnt <= '0;
    else if (!running || preWrap)
      preCnt <= '0;
    else
      preCnt <= preCnt + REG_W'(1);
  end

  // Phase flag: low first, toggles at end of each phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      phaseHigh <= 1'b0;
    else if (!running)
      phaseHigh <= 1'b0;
    else if (phaseDone)
      phaseHigh <= ~phaseHigh;
  end

  assign strb.hold      = !running;
  assign strb.tick      = preWrap;
  assign strb.phaseHigh = phaseHigh;

  assign tick     = preWrap;
  assign sclPhase = running && phaseHigh;
  assign scl      = !running || phaseHigh;

  // Idle input forces a resting bus clock
  assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (scl && !tick && !sclPhase));

  // Prescaler stays inside its window
  assert_pre_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    running |-> preCnt <= pscHeld);

  // Phase changes only when the datapath reports a phase end
  assert_flip_on_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    (running && $past(running) && (phaseHigh != $past(phaseHigh))) |-> $past(phaseDone));

  // A run begins at the start of a prescaler window
  assert_start_clean_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(running) |-> (preCnt == '0));

endmodule

// File: rtl/scl_div_gen.sv
module scl_div_gen
  import scl_div_pkg::*;
#(
  parameter int unsigned REG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [REG_W-1:0] pscIn,
  input  logic [REG_W-1:0] lowIn,
  input  logic [REG_W-1:0] highIn,
  output logic             scl,
  output logic             sclPhase,
  output logic             tick
);

  sclStrobe_t       strb;
  logic [REG_W-1:0] pscHeld;
  logic             phaseDone;

  scl_div_ctrl #(.REG_W(REG_W)) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .pscHeld   (pscHeld),
    .phaseDone (phaseDone),
    .strb      (strb),
    .scl       (scl),
    .sclPhase  (sclPhase),
    .tick      (tick)
  );

  scl_div_dpath #(.REG_W(REG_W)) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .pscIn     (pscIn),
    .lowIn     (lowIn),
    .highIn    (highIn),
    .pscHeld   (pscHeld),
    .phaseDone (phaseDone)
  );

endmodule

// File: tb/scl_div_gen_tb_top.sv
module scl_div_gen_tb_top;

  localparam int REG_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic [REG_W-1:0] pscIn = '0;
  logic [REG_W-1:0] lowIn = '0;
  logic [REG_W-1:0] highIn = '0;
  logic scl, sclPhase, tick;

  always #2.5 clk = ~clk;

  scl_div_gen #(.REG_W(REG_W)) dut_i (
    .clk(clk), .rstN(rstN), .enable(enable),
    .pscIn(pscIn), .lowIn(lowIn), .highIn(highIn),
    .scl(scl), .sclPhase(sclPhase), .tick(tick)
  );

  typedef struct {
    logic  level;
    int    len;
    string tag;
  } runItem_t;

  runItem_t expQ[$];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  bit monOn = 0;
  int expGap = 1;

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int offsetOf(int p);
    if (p == 0) return 7;
    if (p == 1) return 6;
    return 5;
  endfunction

  // Monitor: measures scl runs and tick spacing, compares against queue
  bit started = 0;
  bit prevScl = 1;
  int runLen = 0;
  bit tickSeen = 0;
  int gapCnt = 0;

  always @(negedge clk) begin
    if (!monOn) begin
      started  = 0;
      tickSeen = 0;
      gapCnt   = 0;
    end else begin
      gapCnt++;
      if (tick) begin
        if (tickSeen) check(gapCnt == expGap, "R7 tick spacing", gapCnt, expGap);
        tickSeen = 1;
        gapCnt   = 0;
      end
      if (!started) begin
        if (scl == 1'b0) begin
          started = 1;
          prevScl = 1'b0;
          runLen  = 1;
        end
      end else if (scl == prevScl) begin
        runLen++;
      end else begin
        if (expQ.size() == 0) begin
          check(0, "R3 unexpected scl run", runLen, 0);
        end else begin
          runItem_t it;
          it = expQ.pop_front();
          check(it.level == prevScl, {it.tag, " level"}, int'(prevScl), int'(it.level));
          check(it.len == runLen, {it.tag, " length"}, runLen, it.len);
        end
        check(sclPhase == scl, "R10 phase flag", int'(sclPhase), int'(scl));
        prevScl = scl;
        runLen  = 1;
      end
    end
  end

  // Driver: program, push expected runs, run n periods
  task automatic runPattern(int p, int l, int h, int n, string dTag, bit midChange);
    int lLen, hLen, span;
    enable = 1'b0;
    pscIn  = REG_W'(p);
    lowIn  = REG_W'(l);
    highIn = REG_W'(h);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(scl == 1'b1, "R1 idle scl", int'(scl), 1);
    check(tick == 1'b0, "R1 idle tick", int'(tick), 0);
    check(sclPhase == 1'b0, "R10 idle phase", int'(sclPhase), 0);
    lLen = (p + 1) * (l + offsetOf(p));
    hLen = (p + 1) * (h + offsetOf(p));
    for (int i = 0; i < n; i++) begin
      expQ.push_back('{1'b0, lLen, {"R2 low ", dTag}});
      expQ.push_back('{1'b1, hLen, {"R3 high ", dTag}});
    end
    span = n * (lLen + hLen);
    expGap = p + 1;
    @(posedge clk); #1;
    monOn  = 1;
    enable = 1'b1;
    if (midChange) begin
      repeat (2) @(posedge clk); #1;
      pscIn  = REG_W'(p + 5);
      lowIn  = REG_W'(l + 7);
      highIn = REG_W'(h + 3);
      repeat (span) @(posedge clk); #1;
    end else begin
      repeat (span + 2) @(posedge clk); #1;
    end
    monOn  = 0;
    enable = 1'b0;
    check(expQ.size() == 0, {"R3 all runs seen ", dTag}, expQ.size(), 0);
    expQ.delete();
    repeat (2) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(scl == 1'b1, "R1 reset scl", int'(scl), 1);
    check(tick == 1'b0, "R1 reset tick", int'(tick), 0);
    check(sclPhase == 1'b0, "R10 reset phase", int'(sclPhase), 0);
    @(posedge clk); #1;
    rstN = 1'b1;

    runPattern(0, 1, 2, 2, "R4", 0);
    runPattern(1, 3, 0, 2, "R5", 0);
    runPattern(3, 2, 4, 2, "R6", 0);
    runPattern(2, 1, 3, 2, "R8 frozen", 1);
    runPattern(0, 9, 9, 1, "R8 reload", 0);

    // R9: drop enable mid low phase
    enable = 1'b0;
    pscIn = 16'd4; lowIn = 16'd6; highIn = 16'd6;
    repeat (3) @(posedge clk); #1;
    enable = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(scl == 1'b0, "R9 low before drop", int'(scl), 0);
    @(posedge clk); #1;
    enable = 1'b0;
    @(posedge clk); #1;
    check(scl == 1'b1, "R9 scl after drop", int'(scl), 1);
    check(sclPhase == 1'b0, "R9 phase after drop", int'(sclPhase), 0);
    runPattern(4, 6, 6, 1, "R9 restart R6", 0);

    runPattern(9, 10, 20, 1, "R6 wide", 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule